// File: doc/BRIEF.md
# Fine Frequency Adjustment Calculator

This block turns a signed frequency-offset request, expressed in parts per million scaled by 2^16, into a signed 32-bit correction to the fractional-nanosecond step of a time-of-day counter. The correction is in units of 2^-32 ns. It also takes the counter's nominal period in 32.32 fixed point. The correction is the change in period that gives the requested change in frequency. A positive request shortens the period, so the clock runs faster.

A pulse on `start_i` latches the request. The magnitude is computed as period × |request| / (2^16·10^6 + |request|). Before the divide, the dividend and the divisor are both shifted right by four bits. A restoring divider then produces one quotient bit per clock. After the last bit the result is checked against the signed 32-bit range and the result port is loaded. A one-cycle `done_o` strobe marks the new value. `range_err_o` flags a request that cannot be represented or that exceeds the accepted frequency offset.

Top module: `fadj_calc`

## Requirements
- R1: After reset `corr_o`, `done_o` and `range_err_o` are all 0.
- R2: For a request p ≥ 0 with no error, `corr_o` equals floor(floor(period·p / 16) / (4096000000 + floor(p / 16))).
- R3: For a request p < 0 with no error, `corr_o` is the two's-complement negation of the same quotient, computed with |p| in place of p.
- R4: For a negative request the quotient may be at most 0x80000000. 0x80000000 itself gives `corr_o` = 0x80000000, and any larger quotient sets `range_err_o`.
- R5: For a non-negative request a quotient above 0x7FFFFFFF sets `range_err_o`, and 0x7FFFFFFF is still accepted.
- R6: A request with |p| above 65536000 (1,000,000 ppb scaled by 2^16) sets `range_err_o`, whatever the quotient.
- R7: While `range_err_o` is 1, `corr_o` is 0.
- R8: `done_o` is a one-cycle pulse. It rises in the cycle that follows the 93rd rising edge after the edge that accepted `start_i` (with the default widths, the number of quotient bits is 92, plus one). `corr_o` and `range_err_o` change only with `done_o` and hold their values until the next `done_o`.
- R9: `start_i` is ignored while a calculation is in progress. This includes the cycle between the last quotient bit and `done_o`. A start in the cycle where `done_o` is 1 is accepted.
- R10: A zero request gives `corr_o` = 0 with `range_err_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request strobe, taken when idle |
| period_i | input | PER_W (64) | Nominal period, 32.32 fixed point, ns |
| sppm_i | input | PPM_W (32) | Signed request, ppm × 2^16 |
| corr_o | output | 32 | Signed step correction, 2^-32 ns units |
| done_o | output | 1 | One-cycle result strobe |
| range_err_o | output | 1 | Request out of range for this result |

## Verification
A corrupted remainder or quotient bit inside the divider shows up as a wrong `corr_o` in the `done_o` cycle of that same request. Near the range limits it can also show as a wrong `range_err_o`. A fault in the bit counter or in the busy logic shifts the `done_o` cycle or drops it. The per-clock reference comparison reports this in the first cycle it diverges. If the request sign or the offset-limit flag is latched badly, the correction comes out mirrored, or an error is missing, at the end of the calculation.

// File: rtl/fadj_pkg.sv
package fadj_pkg;
   // width of the signed correction result
   localparam int CORR_W = 32;
   // both divide operands are reduced by this many bits
   localparam int PRE_SHIFT = 4;
   // 10^6 << 12: the 2^16 * 10^6 term after the pre-shift
   localparam longint unsigned DIV_BASE = 64'd1000000 << 12;
   // scaled-ppm units per ppm
   localparam longint unsigned PPM_UNIT = 64'd65536;

   typedef logic [CORR_W-1:0] corr_t;
endpackage

// File: rtl/fadj_prep.sv
module fadj_prep #(
   parameter int PER_W = 64,
   parameter int PPM_W = 32,
   localparam int PROD_W = PER_W + PPM_W,
   localparam int DVD_W  = PROD_W - fadj_pkg::PRE_SHIFT,
   localparam int DVS_W  = PPM_W + 1
) (
   input  logic [PER_W-1:0]        period_i,
   input  logic signed [PPM_W-1:0] sppm_i,
   output logic [PPM_W-1:0]        mag_o,
   output logic [DVD_W-1:0]        dvd_o,
   output logic [DVS_W-1:0]        dvs_o
);
   localparam logic [DVS_W-1:0] BASE = DVS_W'(fadj_pkg::DIV_BASE);

   logic [PROD_W-1:0] prod;

   assign mag_o = sppm_i[PPM_W-1] ? PPM_W'(~sppm_i + 1'b1) : PPM_W'(sppm_i);
   assign prod  = PROD_W'(period_i) * PROD_W'(mag_o);
   assign dvd_o = DVD_W'(prod >> fadj_pkg::PRE_SHIFT);
   assign dvs_o = BASE + DVS_W'(mag_o >> fadj_pkg::PRE_SHIFT);
endmodule

// File: rtl/fadj_divider.sv
module fadj_divider #(
   parameter int DVD_W = 92,
   parameter int DVS_W = 33,
   localparam int CNT_W = $clog2(DVD_W)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load_i,
   input  logic [DVD_W-1:0] dvd_i,
   input  logic [DVS_W-1:0] dvs_i,
   output logic             busy_o,
   output logic             fin_o,
   output logic [DVD_W-1:0] quo_o
);
   logic [DVD_W-1:0] acc;
   logic [DVS_W-1:0] rem;
   logic [DVS_W-1:0] dvs_q;
   logic [CNT_W-1:0] cnt;
   logic             run;
   logic             fin;

   logic [DVS_W:0]   trial;
   logic [DVS_W:0]   diff;
   logic             ge;

   // restoring step: bring down one dividend bit, subtract if it fits
   assign trial = {rem, acc[DVD_W-1]};
   assign diff  = trial - {1'b0, dvs_q};
   assign ge    = trial >= {1'b0, dvs_q};

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         acc   <= '0;
         rem   <= '0;
         dvs_q <= '0;
         cnt   <= '0;
         run   <= 1'b0;
         fin   <= 1'b0;
      end else begin
         fin <= 1'b0;
         if (load_i && !run) begin
            acc   <= dvd_i;
            rem   <= '0;
            dvs_q <= dvs_i;
            cnt   <= CNT_W'(DVD_W - 1);
            run   <= 1'b1;
         end else if (run) begin
            acc <= {acc[DVD_W-2:0], ge};
            rem <= ge ? diff[DVS_W-1:0] : trial[DVS_W-1:0];
            cnt <= cnt - 1'b1;
            if (cnt == '0) begin
               run <= 1'b0;
               fin <= 1'b1;
            end
         end
      end
   end

   assign busy_o = run;
   assign fin_o  = fin;
   assign quo_o  = acc;
endmodule

// File: rtl/fadj_limit.sv
module fadj_limit #(
   parameter int DVD_W = 92
) (
   input  logic [DVD_W-1:0]    quo_i,
   input  logic                neg_i,
   input  logic                big_i,
   output fadj_pkg::corr_t     corr_o,
   output logic                err_o
);
   localparam int CW = fadj_pkg::CORR_W;

   logic over;
   logic pos_ok;
   logic neg_ok;
   logic [CW-1:0] low;

   assign low    = quo_i[CW-1:0];
   assign over   = |quo_i[DVD_W-1:CW];
   // largest positive value: sign bit clear
   assign pos_ok = !over && !low[CW-1];
   // negative side also reaches exactly 2^(CW-1)
   assign neg_ok = !over && (!low[CW-1] || (low[CW-2:0] == '0));
   assign err_o  = big_i || (neg_i ? !neg_ok : !pos_ok);
   assign corr_o = err_o ? '0 : (neg_i ? (~low + 1'b1) : low);
endmodule

// File: rtl/fadj_calc.sv
module fadj_calc #(
   parameter int PER_W   = 64,
   parameter int PPM_W   = 32,
   parameter int MAX_PPB = 1000000
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        start_i,
   input  logic [PER_W-1:0]            period_i,
   input  logic signed [PPM_W-1:0]     sppm_i,
   output logic [fadj_pkg::CORR_W-1:0] corr_o,
   output logic                        done_o,
   output logic                        range_err_o
);
   localparam int DVD_W = PER_W + PPM_W - fadj_pkg::PRE_SHIFT;
   localparam int DVS_W = PPM_W + 1;
   localparam longint unsigned MAX_SCALED =
      (longint'(MAX_PPB) * fadj_pkg::PPM_UNIT) / 64'd1000;

   if (PPM_W < 32) begin : g_ppm_chk
      $error("PPM_W must hold the divisor base");
   end
   if (PER_W < 36) begin : g_per_chk
      $error("PER_W too small for 32.32 period");
   end
   if (PPM_W > 63) begin : g_ppm_max_chk
      $error("PPM_W too wide for limit compare");
   end

   logic [PPM_W-1:0] mag;
   logic [DVD_W-1:0] dvd;
   logic [DVS_W-1:0] dvs;
   logic [DVD_W-1:0] quo;
   logic             div_busy;
   logic             div_fin;
   logic             busy_w;
   logic             accept;
   logic             neg_q;
   logic             big_q;
   fadj_pkg::corr_t  corr_n;
   logic             err_n;
   fadj_pkg::corr_t  corr_q;
   logic             err_q;
   logic             done_q;

   fadj_prep #(.PER_W(PER_W), .PPM_W(PPM_W)) u_prep (
      .period_i (period_i),
      .sppm_i   (sppm_i),
      .mag_o    (mag),
      .dvd_o    (dvd),
      .dvs_o    (dvs)
   );

   assign busy_w = div_busy | div_fin;
   assign accept = start_i & ~busy_w;

   fadj_divider #(.DVD_W(DVD_W), .DVS_W(DVS_W)) u_div (
      .clk    (clk),
      .rst_n  (rst_n),
      .load_i (accept),
      .dvd_i  (dvd),
      .dvs_i  (dvs),
      .busy_o (div_busy),
      .fin_o  (div_fin),
      .quo_o  (quo)
   );

   fadj_limit #(.DVD_W(DVD_W)) u_lim (
      .quo_i  (quo),
      .neg_i  (neg_q),
      .big_i  (big_q),
      .corr_o (corr_n),
      .err_o  (err_n)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         neg_q  <= 1'b0;
         big_q  <= 1'b0;
         corr_q <= '0;
         err_q  <= 1'b0;
         done_q <= 1'b0;
      end else begin
         if (accept) begin
            neg_q <= sppm_i[PPM_W-1];
            big_q <= 64'(mag) > MAX_SCALED;
         end
         done_q <= div_fin;
         if (div_fin) begin
            corr_q <= corr_n;
            err_q  <= err_n;
         end
      end
   end

   assign corr_o      = corr_q;
   assign done_o      = done_q;
   assign range_err_o = err_q;
endmodule

// File: rtl/fadj_calc_chk.sv
module fadj_calc_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        start,
   input logic        busy,
   input logic        done,
   input logic        err,
   input logic [31:0] corr,
   input logic        neg,
   input logic        big
);
   // R8
   done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   // R8
   hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !done |=> (!done || $past(busy)) && ($stable(corr) || done));
   // R7
   err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> corr == 32'd0);
   // R3
   neg_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && !err && neg |-> (corr == 32'd0) || corr[31]);
   // R5
   pos_sign_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && !err && !neg |-> !corr[31]);
   // R6
   big_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
      done && big |-> err);
   // R9
   busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
      busy && start |=> $stable(neg) && $stable(big));
endmodule

bind fadj_calc fadj_calc_chk u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .start (start_i),
   .busy  (busy_w),
   .done  (done_o),
   .err   (range_err_o),
   .corr  (corr_o),
   .neg   (neg_q),
   .big   (big_q)
);

// File: tb/fadj_calc_test.sv
module fadj_calc_test;
   localparam int QW = 92;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               start = 1'b0;
   logic [63:0]        period = '0;
   logic signed [31:0] sppm = '0;
   logic [31:0]        corr;
   logic               done;
   logic               rerr;

   int total = 0;
   int bad = 0;
   string cur_req = "R1";

   // reference model state
   int          cnt = 0;
   logic [31:0] exp_corr = '0;
   logic        exp_err = 1'b0;
   logic        exp_done = 1'b0;
   logic [31:0] pend_corr = '0;
   logic        pend_err = 1'b0;

   always #4 clk = ~clk;

   fadj_calc uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .start_i     (start),
      .period_i    (period),
      .sppm_i      (sppm),
      .corr_o      (corr),
      .done_o      (done),
      .range_err_o (rerr)
   );

   task automatic ref_calc(input logic [63:0] per, input longint p,
                           output logic [31:0] c, output logic e);
      longint      m;
      logic [95:0] dvd;
      logic [95:0] dvs;
      logic [95:0] q;
      m   = (p < 0) ? -p : p;
      dvd = (96'(per) * 96'(m)) / 96'd16;
      dvs = 96'(64'd4096000000 + 64'(m / 16));
      q   = dvd / dvs;
      if (p < 0) e = (m > 65536000) || (q > 96'h80000000);
      else       e = (m > 65536000) || (q > 96'h7FFFFFFF);
      if (e)          c = 32'd0;
      else if (p < 0) c = 32'(96'd0 - q);
      else            c = q[31:0];
   endtask

   always @(posedge clk) begin
      if (!rst_n) begin
         cnt = 0;
         exp_done = 1'b0;
         exp_corr = '0;
         exp_err = 1'b0;
      end else if (cnt > 0) begin
         cnt = cnt - 1;
         exp_done = (cnt == 0);
         if (cnt == 0) begin
            exp_corr = pend_corr;
            exp_err = pend_err;
         end
      end else begin
         exp_done = 1'b0;
         if (start) begin
            ref_calc(period, longint'(sppm), pend_corr, pend_err);
            cnt = QW + 1;
         end
      end
   end

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] expv);
      total++;
      if (act !== expv) begin
         bad++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, expv);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         chk(cur_req, "done", 32'(done), 32'(exp_done));
         chk(cur_req, "corr", corr, exp_corr);
         chk(cur_req, "range_err", 32'(rerr), 32'(exp_err));
      end
   end

   task automatic req(input logic [63:0] per, input longint p, input string tag);
      @(negedge clk);
      cur_req = tag;
      period = per;
      sppm = 32'(p);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (QW + 4) @(negedge clk);
   endtask

   int wd = 0;
   always @(posedge clk) begin
      wd++;
      if (wd > 150000) begin
         bad++;
         $display("FAIL watchdog expired");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   localparam logic [63:0] P3 = 64'd3 << 32;
   localparam logic [63:0] DV16 = 64'd4096000001;

   initial begin
      logic [63:0] big;
      big = 64'd2147483648 * DV16;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk("R1", "corr", corr, 32'd0);
      chk("R1", "done", 32'(done), 32'd0);
      chk("R1", "range_err", 32'(rerr), 32'd0);
      rst_n = 1'b1;
      req(P3, 64'sd655360, "R2");
      req((64'd8 << 32) + 64'h12345678, 64'sd1234567, "R2");
      req(P3, -64'sd655360, "R3");
      req((64'd5 << 32) + 64'h9ABC0000, -64'sd40000000, "R3");
      req(P3, 64'sd0, "R10");
      req(P3, 64'sd65536000, "R6");
      req(P3, 64'sd65536001, "R6");
      req(P3, -64'sd65536001, "R7");
      req(P3, -64'sd2147483648, "R6");
      req(big - 64'd1, 64'sd16, "R5");
      req(big, 64'sd16, "R5");
      req(big, -64'sd16, "R4");
      req(big + DV16, -64'sd16, "R4");
      // R9: second start while busy must not change the result
      @(negedge clk);
      cur_req = "R9";
      period = P3;
      sppm = 32'sd100000;
      start = 1'b1;
      @(negedge clk);
      sppm = -32'sd777777;
      repeat (10) @(negedge clk);
      start = 1'b0;
      repeat (QW + 4) @(negedge clk);
      // R8: start held high, back-to-back calculations
      cur_req = "R8";
      period = P3 + 64'd12345;
      sppm = 32'sd3000000;
      start = 1'b1;
      repeat (2 * QW + 6) @(negedge clk);
      start = 1'b0;
      repeat (QW + 4) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule